// File: doc/BRIEF.md
# Handshake-Stepped Memory Range Walker

This block walks a byte-wide memory port across a contiguous, inclusive address range, doing one access per handshake strobe. When the enable input is raised, the block takes a snapshot of a start address, an end address and a direction (read or write). It then spends two fixed preparation cycles. After that, each strobe on the step input becomes exactly one single-cycle access on the memory side, and the cursor then moves up by one.

Once the access at the end address has been issued, the block raises a completion flag. The flag stays up for as long as the enable stays high. Dropping the enable at any time sends the walker back to its waiting state, where a new high enable starts a fresh range. Read data from the memory is forwarded to the requester without a register, so it is valid in the same cycle as the access pulse. A typical use has a producer or consumer that strobes once per byte. One pass fills a buffer, and a second pass with the other direction drains it.

Top module: `mem_range_walker`

## Requirements
- R1: While rst_n is low, mem_en_o, mem_we_o and done_o are 0 and mem_addr_o is 0.
- R2: An idle walker that samples en_i high at a clock edge captures start_addr_i, end_addr_i and mode_i (1 = write, 0 = read) at that edge. Later changes on these three inputs have no effect on the walk in progress.
- R3: step_i is ignored at the first and second edges after the capture edge. The earliest step that can cause an access is sampled at the third edge.
- R4: Each accepted step (step_i high at an edge while running) makes mem_en_o high for the one cycle after that edge, with mem_addr_o equal to the cursor. The cursor then goes up by one, wrapping modulo 2^19.
- R5: During an access pulse, mem_we_o equals the captured mode. On a write, mem_wdata_o holds the wdata_i value sampled at the accepting edge. mem_we_o is never 1 without mem_en_o.
- R6: rdata_o follows mem_rdata_i combinationally, so read data is taken in the cycle that mem_en_o is high.
- R7: The end address is inclusive. A range whose start equals its end makes exactly one access.
- R8: done_o rises in the same cycle as the access pulse for the end address. It stays high while en_i stays high, and step_i is ignored during that time.
- R9: en_i sampled low at any edge puts the walker in its idle state. The cycle after that edge shows done_o = 0 and mem_en_o = 0, even if step_i was high. step_i is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Starts a walk when high from idle; low aborts or releases |
| mode_i | input | 1 | Direction captured at start: 1 write, 0 read |
| start_addr_i | input | 19 | First address of the range |
| end_addr_i | input | 19 | Last address of the range (inclusive) |
| wdata_i | input | 8 | Byte written on each accepted write step |
| step_i | input | 1 | Handshake strobe, one access per sampled high |
| mem_addr_o | output | 19 | Memory address of the current access |
| mem_we_o | output | 1 | Memory write enable for the access |
| mem_en_o | output | 1 | Memory access enable, one cycle per access |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| rdata_o | output | 8 | Read data forwarded to the requester |
| done_o | output | 1 | Range complete, held until en_i falls |

## Verification
The hardest cases to reach are the ones where a strobe lands exactly on a boundary. These are the two preparation edges, the edge that issues the final access, and an edge where the enable falls while a strobe is high. The stimulus keeps the step input high on every cycle from the moment the enable rises, so both setup edges see a strobe. It also keeps strobing while the completion flag is held, and it aborts with a strobe present. A further run crosses the top of the address space to reach the wrap. A write pass followed by a read pass over the same range, against a behavioural byte array, shows that data survives the round trip.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    WK_IDLE    = 3'd0,
    WK_SETUP_A = 3'd1,
    WK_SETUP_B = 3'd2,
    WK_RUN     = 3'd3,
    WK_DONE    = 3'd4
  } walk_state_e;
endpackage

// File: rtl/walk_addr.sv
module walk_addr #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic              mode_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] end_q, end_d;
  logic              mode_q, mode_d;
  logic              cur_en;

  assign last_o = (cur_q == end_q);

  always_comb begin
    cur_en = load_i | (adv_i & ~last_o);
    cur_d  = load_i ? start_i : (cur_q + ONE);
    end_d  = end_i;
    mode_d = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      end_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (cur_en) cur_q <= cur_d;
      if (load_i) begin
        end_q  <= end_d;
        mode_q <= mode_d;
      end
    end
  end

  assign cur_o  = cur_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic step_i,
  input  logic last_i,
  output logic load_o,
  output logic access_o,
  output logic setup_o,
  output logic done_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    access_o = 1'b0;
    if (state_q == WK_IDLE) begin
      if (en_i) begin
        load_o  = 1'b1;
        state_d = WK_SETUP_A;
      end
    end else if (!en_i) begin
      state_d = WK_IDLE;
    end else begin
      case (state_q)
        WK_SETUP_A: state_d = WK_SETUP_B;
        WK_SETUP_B: state_d = WK_RUN;
        WK_RUN: begin
          if (step_i) begin
            access_o = 1'b1;
            if (last_i) state_d = WK_DONE;
          end
        end
        WK_DONE: state_d = WK_DONE;
        default: state_d = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  assign setup_o = (state_q == WK_SETUP_A) || (state_q == WK_SETUP_B);
  assign done_o  = (state_q == WK_DONE);

  // R8
  done_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !access_o);
endmodule

// File: rtl/mem_range_walker.sv
module mem_range_walker #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_en_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic              load, access, setup, last, mode;
  logic [ADDR_W-1:0] cur;

  walk_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .step_i   (step_i),
    .last_i   (last),
    .load_o   (load),
    .access_o (access),
    .setup_o  (setup),
    .done_o   (done_o)
  );

  walk_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .adv_i   (access),
    .start_i (start_addr_i),
    .end_i   (end_addr_i),
    .mode_i  (mode_i),
    .cur_o   (cur),
    .mode_o  (mode),
    .last_o  (last)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              en_q, we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      en_q <= access;
      we_q <= access & mode;
      if (access) begin
        addr_q  <= cur;
        wdata_q <= wdata_i;
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_en_o    = en_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
  assign rdata_o     = mem_rdata_i;

  // R4
  consecutive_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && $past(mem_en_o)) |-> ((mem_addr_o - $past(mem_addr_o)) == ADDR_W'(1)));
  // R3
  setup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup |=> !mem_en_o);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && en_i) |=> done_o);
  // R9
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!done_o && !mem_en_o));
  // R5
  we_within_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o);
endmodule

// File: tb/mem_range_walker_tb.sv
module mem_range_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_i, mode_i, step_i;
  logic [AW-1:0] start_addr_i, end_addr_i;
  logic [7:0]    wdata_i;
  logic [AW-1:0] mem_addr_o;
  logic          mem_we_o, mem_en_o, done_o;
  logic [7:0]    mem_wdata_o, mem_rdata_i, rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_range_walker dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .start_addr_i(start_addr_i), .end_addr_i(end_addr_i),
    .wdata_i(wdata_i), .step_i(step_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_en_o(mem_en_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .rdata_o(rdata_o), .done_o(done_o)
  );

  // behavioural byte memory
  logic [7:0] mem [0:1023];
  always_comb mem_rdata_i = mem[mem_addr_o[9:0]];
  always @(posedge clk) if (mem_en_o && mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    pat = a[7:0] * 8'd3 + 8'h11 + {6'd0, a[9:8]};
  endfunction

  int     vectors = 0;
  int     fails = 0;
  string  cur_req = "R1";
  bit     chk_read = 1'b0;
  bit     use_pat = 1'b0;
  bit     finished = 1'b0;

  // reference model
  int            m_ph = 0;
  logic [AW-1:0] m_cur = '0, m_end = '0, x_addr = '0;
  logic          m_mode = 1'b0, x_en = 1'b0, x_we = 1'b0, x_done = 1'b0;
  logic [7:0]    x_wd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; x_en = 0; x_we = 0; x_done = 0;
    end else begin
      x_en = 0; x_we = 0;
      if (m_ph == 0) begin
        if (en_i) begin m_cur = start_addr_i; m_end = end_addr_i; m_mode = mode_i; m_ph = 1; end
      end else if (!en_i) m_ph = 0;
      else if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2) m_ph = 3;
      else if (m_ph == 3 && step_i) begin
        x_en = 1; x_we = m_mode; x_addr = m_cur; x_wd = wdata_i;
        if (m_cur == m_end) m_ph = 4; else m_cur = m_cur + AW'(1);
      end
      x_done = (m_ph == 4);
    end
  end

  always @* wdata_i = use_pat ? pat(m_cur) : 8'hEE;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check("mem_en_o", 32'(mem_en_o), 32'(x_en));
    check("done_o", 32'(done_o), 32'(x_done));
    check("mem_we_o", 32'(mem_we_o), 32'(x_we));
    if (x_en) check("mem_addr_o", 32'(mem_addr_o), 32'(x_addr));
    if (x_we) check("mem_wdata_o", 32'(mem_wdata_o), 32'(x_wd));
    if (chk_read && mem_en_o && !mem_we_o) begin
      cur_req = "R6";
      check("rdata_o", 32'(rdata_o), 32'(pat(mem_addr_o)));
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // drive step_i from a bit pattern, one bit per cycle
  task automatic steps(input int n, input logic [31:0] p);
    for (int i = 0; i < n; i++) begin step_i = p[i % 32]; tick(1); end
    step_i = 1'b0;
  endtask

  task automatic begin_walk(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic m);
    start_addr_i = s; end_addr_i = e; mode_i = m; en_i = 1'b1;
  endtask

  task automatic end_run;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    end_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    rst_n = 1'b0; en_i = 1'b0; mode_i = 1'b0; step_i = 1'b0;
    start_addr_i = '0; end_addr_i = '0;
    tick(3);
    // R1 reset state
    cur_req = "R1";
    check("mem_en_o", 32'(mem_en_o), 0);
    check("mem_we_o", 32'(mem_we_o), 0);
    check("done_o", 32'(done_o), 0);
    check("mem_addr_o", 32'(mem_addr_o), 0);
    rst_n = 1'b1; tick(2);

    // R3 R5 write pass, strobing from the capture cycle on
    cur_req = "R3"; use_pat = 1'b1;
    begin_walk(19'd10, 19'd25, 1'b1);
    step_i = 1'b1; tick(1);
    steps(4, 32'hFFFF_FFFF);
    cur_req = "R5";
    steps(30, 32'hFFFF_FFFF);
    // R8 done held with strobes still arriving
    cur_req = "R8";
    steps(6, 32'h0000_0015);
    en_i = 1'b0; tick(2);

    // R2 R6 read pass with sparse strobes, range inputs change mid-walk
    cur_req = "R2"; use_pat = 1'b0; chk_read = 1'b1;
    begin_walk(19'd10, 19'd25, 1'b0);
    tick(1);
    start_addr_i = 19'd300; end_addr_i = 19'd12; mode_i = 1'b1;
    steps(60, 32'h9249_2493);
    en_i = 1'b0; tick(2);
    chk_read = 1'b0;

    // R7 single access range
    cur_req = "R7"; use_pat = 1'b1;
    begin_walk(19'd40, 19'd40, 1'b1);
    steps(10, 32'hFFFF_FFFF);
    en_i = 1'b0; tick(2);
    cur_req = "R7"; chk_read = 1'b1;
    begin_walk(19'd40, 19'd40, 1'b0);
    steps(8, 32'h0000_00F0);
    en_i = 1'b0; chk_read = 1'b0; tick(2);

    // R9 abort with a strobe present, then strobes while idle
    cur_req = "R9";
    begin_walk(19'd100, 19'd200, 1'b1);
    steps(6, 32'hFFFF_FFFF);
    step_i = 1'b1; en_i = 1'b0; tick(1);
    steps(5, 32'hFFFF_FFFF);

    // R4 wrap across the top of the address space
    cur_req = "R4";
    begin_walk(19'h7FFFE, 19'h00001, 1'b1);
    steps(12, 32'h0000_0FFF);
    en_i = 1'b0; tick(3);
    end_run();
  end
endmodule